// File: doc/BRIEF.md
# Adaptive Line Comb Chroma Filter

This block cleans cross-colour out of demodulated baseband chroma. It takes U and V samples, plus the notched luma of the same pixel, at a gated pixel rate. Two internal line memories give the current line (0H), the previous line (1H) and the line before that (2H) at the same column. The output is always aligned to the centre line, 1H.

Two chroma estimates are formed for every pixel. The first is a vertical three-line comb. For PAL it adds a crosstalk-cancelling term whose sign follows the PAL switch of the centre line. The second is a horizontal notch on the centre line, with taps four samples apart. A failure measure is computed for each estimate from the luma and chroma differences across its taps. In automatic mode the estimate with the smaller failure is used. A mode input can also force either estimate.

The block outputs:
- the chosen U and V;
- the high-frequency luma left behind in each channel, which is the centre-tap chroma minus the chosen chroma;
- the per-pixel mode decision;
- the centre-line luma, aligned with the other outputs.

Top module: `acf_comb_filter`

## Requirements
- R1: While rst_ni is low, valid_o, u_o, v_o, hf_u_o, hf_v_o, comb_sel_o and y_o are all zero.
- R2: All samples are two's complement, W bits wide. Each enable with en_i high is one pixel, and the line length is LINE_LEN pixels. After the enable of pixel n, the outputs describe centre column c = n-5. y_o equals the luma input of pixel c-LINE_LEN.
- R3: With pal_i low, the comb estimate of a channel is (x[c] + 2*x[c-L] + x[c-2L] + 2) >> 2, using an arithmetic shift. Here L is LINE_LEN.
- R4: With pal_i high, 4*(x[c] - x[c-2L]) is added to the comb sum before the shift when the PAL switch of the centre pixel (palsw_i of pixel c-L) is 1. The same term is subtracted when that switch is 0.
- R5: The notch estimate is (x[c-L+4] + 2*x[c-L] + x[c-L-4] + 2) >> 2, taken on the centre line.
- R6: Only when mode_i[2] or mode_i[1] is set, the comb estimate is chosen if its error is less than or equal to the notch error; ties go to comb. The comb error is |y0-y1| + |y2-y1| + |u0-u2| + |v0-v2|, taken over the 0H, 1H and 2H samples at column c. The notch error is |ya-y1| + |yb-y1| + |ua-ub| + |va-vb|, where a and b are the 1H samples at c+4 and c-4.
- R7: Only when mode_i[2:1] is 00, mode_i[0] forces the choice: 0 picks notch and 1 picks comb. comb_sel_o is 1 when the comb estimate drives u_o and v_o.
- R8: hf_u_o and hf_v_o equal the centre-tap chroma x[c-L] minus the chosen estimate, saturated to W bits.
- R9: A comb result outside the W-bit signed range is clamped to the most positive or most negative value.
- R10: The outputs change only on a clock edge where en_i is high. valid_o is en_i delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Pixel enable |
| y_i | input | W | Notched luma of the incoming pixel |
| u_i | input | W | Demodulated U of the incoming pixel |
| v_i | input | W | Demodulated V of the incoming pixel |
| pal_i | input | 1 | Enables the crosstalk-cancelling term |
| palsw_i | input | 1 | PAL switch state of the incoming line |
| mode_i | input | 3 | Forced notch (000), forced comb (001) or automatic |
| valid_o | output | 1 | Outputs were updated on the last edge |
| u_o | output | W | Chosen U |
| v_o | output | W | Chosen V |
| hf_u_o | output | W | High-frequency residue in U |
| hf_v_o | output | W | High-frequency residue in V |
| comb_sel_o | output | 1 | 1 when the comb estimate was chosen |
| y_o | output | W | Centre-line luma |

## Verification
Five stimulus families are used:
- A flat field gives zero error for both estimates, so it exposes the tie rule.
- A field that changes only from line to line makes the comb fail while the notch stays clean.
- A field that changes only along the line makes the notch fail while the comb stays clean. Together with the previous family, this shows whether the comparison points the right way.
- Hashed noise reaches every term of both error sums and both filters.
- Full-scale opposite-sign lines with the PAL term enabled drive the comb into saturation.

Each family runs under every mode value class and with the PAL term both on and off. Idle cycles are spread through the stream, so a pipeline that advances without an enable shows up.

// File: rtl/acf_pkg.sv
package acf_pkg;
  localparam int ACF_FIELDS = 3;  // y, u, v packed per pixel word

  function automatic logic mode_is_auto(input logic [2:0] m);
    return |m[2:1];
  endfunction
endpackage

// File: rtl/acf_line_taps.sv
module acf_line_taps #(
  parameter int W        = 10,
  parameter int LINE_LEN = 858
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [3*W-1:0]  pix_i,
  input  logic            psw_i,
  output logic [3*W-1:0]  tap0_o,
  output logic [3*W-1:0]  tap1_o,
  output logic [3*W-1:0]  tap2_o,
  output logic            psw1_o
);
  localparam int PW = 3 * W;
  localparam int AW = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

  logic [AW-1:0] addr_q;
  logic [PW:0]   mem1_q [LINE_LEN];
  logic [PW-1:0] mem2_q [LINE_LEN];
  logic [PW:0]   rd1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      tap0_o <= '0;
    end else if (en_i) begin
      addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
      tap0_o <= pix_i;
    end
  end

  // single port per line, old word read out as the new one is written
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      rd1_q          <= mem1_q[addr_q];
      mem1_q[addr_q] <= {psw_i, pix_i};
      tap2_o         <= mem2_q[addr_q];
      mem2_q[addr_q] <= mem1_q[addr_q][PW-1:0];
    end
  end

  assign tap1_o = rd1_q[PW-1:0];
  assign psw1_o = rd1_q[PW];
endmodule

// File: rtl/acf_dly.sv
module acf_dly #(
  parameter int PW = 30,
  parameter int N  = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [PW-1:0] d_i,
  output logic [PW-1:0] q_o
);
  logic [N-1:0][PW-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else if (en_i) begin
      stg_q[0] <= d_i;
      for (int i = 1; i < N; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[N-1];
endmodule

// File: rtl/acf_err.sv
module acf_err #(
  parameter int W = 10
) (
  input  logic [W-1:0] y0_i, y1_i, y2_i, ya_i, yb_i,
  input  logic [W-1:0] u0_i, u2_i, ua_i, ub_i,
  input  logic [W-1:0] v0_i, v2_i, va_i, vb_i,
  output logic [W+2:0] comb_err_o,
  output logic [W+2:0] notch_err_o
);
  localparam int EW = W + 3;

  function automatic logic [W:0] adiff(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [W:0] d;
    d = $signed({a[W-1], a}) - $signed({b[W-1], b});
    return d[W] ? (W+1)'(-d) : (W+1)'(d);
  endfunction

  always_comb begin
    comb_err_o  = EW'(adiff(y0_i, y1_i)) + EW'(adiff(y2_i, y1_i)) +
                  EW'(adiff(u0_i, u2_i)) + EW'(adiff(v0_i, v2_i));
    notch_err_o = EW'(adiff(ya_i, y1_i)) + EW'(adiff(yb_i, y1_i)) +
                  EW'(adiff(ua_i, ub_i)) + EW'(adiff(va_i, vb_i));
  end
endmodule

// File: rtl/acf_chan.sv
module acf_chan #(
  parameter int W = 10
) (
  input  logic [W-1:0] t0_i,
  input  logic [W-1:0] t1_i,
  input  logic [W-1:0] t2_i,
  input  logic [W-1:0] na_i,
  input  logic [W-1:0] nb_i,
  input  logic         pal_i,
  input  logic         psw_i,
  input  logic         use_comb_i,
  output logic [W-1:0] sel_o,
  output logic [W-1:0] hf_o
);
  localparam int SW = W + 4;
  localparam logic signed [SW-1:0] HI  = SW'((2 ** (W - 1)) - 1);
  localparam logic signed [SW-1:0] LO  = ~HI;
  localparam logic signed [SW-1:0] RND = SW'(2);

  function automatic logic signed [SW-1:0] ext(input logic [W-1:0] x);
    return {{(SW-W){x[W-1]}}, x};
  endfunction

  function automatic logic [W-1:0] sat(input logic signed [SW-1:0] x);
    if (x > HI) return HI[W-1:0];
    if (x < LO) return LO[W-1:0];
    return x[W-1:0];
  endfunction

  logic signed [SW-1:0] csum, xtalk, nsum, csh, nsh, hdiff;

  always_comb begin
    xtalk = ext(t0_i) - ext(t2_i);
    csum  = ext(t0_i) + (ext(t1_i) <<< 1) + ext(t2_i) + RND;
    if (pal_i) csum = psw_i ? csum + (xtalk <<< 2) : csum - (xtalk <<< 2);
    nsum  = ext(na_i) + (ext(t1_i) <<< 1) + ext(nb_i) + RND;
    csh   = csum >>> 2;
    nsh   = nsum >>> 2;
    sel_o = use_comb_i ? sat(csh) : sat(nsh);
    hdiff = ext(t1_i) - ext(sel_o);
    hf_o  = sat(hdiff);
  end
endmodule

// File: rtl/acf_comb_filter.sv
module acf_comb_filter
  import acf_pkg::*;
#(
  parameter int W        = 10,
  parameter int LINE_LEN = 858,
  parameter int NSPACE   = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] v_i,
  input  logic         pal_i,
  input  logic         palsw_i,
  input  logic [2:0]   mode_i,
  output logic         valid_o,
  output logic [W-1:0] u_o,
  output logic [W-1:0] v_o,
  output logic [W-1:0] hf_u_o,
  output logic [W-1:0] hf_v_o,
  output logic         comb_sel_o,
  output logic [W-1:0] y_o
);
  localparam int PW = ACF_FIELDS * W;
  localparam int EW = W + 3;
  localparam int YL = 2 * W;  // field offsets inside a pixel word
  localparam int UL = W;
  localparam int VL = 0;

  logic [PW-1:0] tap0, tap1, tap2, c0, c1, c2, b1;
  logic          psw1, psw_c;
  logic [EW-1:0] comb_err, notch_err;
  logic          use_comb;
  logic [1:0][W-1:0] sel_w, hf_w;

  acf_line_taps #(.W(W), .LINE_LEN(LINE_LEN)) u_taps (
    .clk_i, .rst_ni, .en_i,
    .pix_i({y_i, u_i, v_i}), .psw_i(palsw_i),
    .tap0_o(tap0), .tap1_o(tap1), .tap2_o(tap2), .psw1_o(psw1)
  );

  acf_dly #(.PW(PW), .N(NSPACE)) u_d0 (.clk_i, .rst_ni, .en_i, .d_i(tap0), .q_o(c0));
  acf_dly #(.PW(PW), .N(NSPACE)) u_d1 (.clk_i, .rst_ni, .en_i, .d_i(tap1), .q_o(c1));
  acf_dly #(.PW(PW), .N(NSPACE)) u_d1b (.clk_i, .rst_ni, .en_i, .d_i(c1), .q_o(b1));
  acf_dly #(.PW(PW), .N(NSPACE)) u_d2 (.clk_i, .rst_ni, .en_i, .d_i(tap2), .q_o(c2));
  acf_dly #(.PW(1), .N(NSPACE)) u_dp (.clk_i, .rst_ni, .en_i, .d_i(psw1), .q_o(psw_c));

  acf_err #(.W(W)) u_err (
    .y0_i(c0[YL+:W]), .y1_i(c1[YL+:W]), .y2_i(c2[YL+:W]), .ya_i(tap1[YL+:W]), .yb_i(b1[YL+:W]),
    .u0_i(c0[UL+:W]), .u2_i(c2[UL+:W]), .ua_i(tap1[UL+:W]), .ub_i(b1[UL+:W]),
    .v0_i(c0[VL+:W]), .v2_i(c2[VL+:W]), .va_i(tap1[VL+:W]), .vb_i(b1[VL+:W]),
    .comb_err_o(comb_err), .notch_err_o(notch_err)
  );

  assign use_comb = mode_is_auto(mode_i) ? (comb_err <= notch_err) : mode_i[0];

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    localparam int LSB = (ch == 0) ? UL : VL;
    acf_chan #(.W(W)) u_chan (
      .t0_i(c0[LSB+:W]), .t1_i(c1[LSB+:W]), .t2_i(c2[LSB+:W]),
      .na_i(tap1[LSB+:W]), .nb_i(b1[LSB+:W]),
      .pal_i, .psw_i(psw_c), .use_comb_i(use_comb),
      .sel_o(sel_w[ch]), .hf_o(hf_w[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      u_o        <= '0;
      v_o        <= '0;
      hf_u_o     <= '0;
      hf_v_o     <= '0;
      comb_sel_o <= 1'b0;
      y_o        <= '0;
    end else begin
      valid_o <= en_i;
      if (en_i) begin
        u_o        <= sel_w[0];
        v_o        <= sel_w[1];
        hf_u_o     <= hf_w[0];
        hf_v_o     <= hf_w[1];
        comb_sel_o <= use_comb;
        y_o        <= c1[YL+:W];
      end
    end
  end
endmodule

// File: rtl/acf_comb_filter_chk.sv
module acf_comb_filter_chk #(
  parameter int W  = 10,
  parameter int EW = 13
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [2:0]   mode_i,
  input logic         valid_o,
  input logic [W-1:0] u_o,
  input logic [W-1:0] v_o,
  input logic [W-1:0] hf_u_o,
  input logic [W-1:0] hf_v_o,
  input logic         comb_sel_o,
  input logic [W-1:0] y_o,
  input logic [EW-1:0] comb_err,
  input logic [EW-1:0] notch_err
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r1: assert (!valid_o && u_o == '0 && v_o == '0 && hf_u_o == '0 &&
                               hf_v_o == '0 && !comb_sel_o && y_o == '0);
    end
  end

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(u_o) && $stable(v_o) && $stable(hf_u_o) && $stable(hf_v_o) &&
               $stable(comb_sel_o) && $stable(y_o)));

  p_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_o);

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);

  p_force_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i[2:1] == 2'b00) |=> (comb_sel_o == $past(mode_i[0])));

  p_auto_pick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && mode_i[2:1] != 2'b00) |=> (comb_sel_o == ($past(comb_err) <= $past(notch_err))));
endmodule

bind acf_comb_filter acf_comb_filter_chk #(.W(W), .EW(EW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
  .valid_o(valid_o), .u_o(u_o), .v_o(v_o), .hf_u_o(hf_u_o), .hf_v_o(hf_v_o),
  .comb_sel_o(comb_sel_o), .y_o(y_o),
  .comb_err(comb_err), .notch_err(notch_err)
);

// File: tb/acf_comb_filter_tb.sv
module acf_comb_filter_tb;
  localparam int W  = 8;
  localparam int L  = 12;
  localparam int NS = 4;
  localparam int N  = 8 * L;
  localparam int LAT = NS + 1;

  logic clk = 1'b0, rst_ni = 1'b0, en_i = 1'b0;
  logic [W-1:0] y_i = '0, u_i = '0, v_i = '0;
  logic pal_i = 1'b0, palsw_i = 1'b0;
  logic [2:0] mode_i = 3'b000;
  logic valid_o, comb_sel_o;
  logic [W-1:0] u_o, v_o, hf_u_o, hf_v_o, y_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int sy[N], su[N], sv[N], sp[N];

  always #4 clk = ~clk;

  acf_comb_filter #(.W(W), .LINE_LEN(L), .NSPACE(NS)) u_dut (
    .clk_i(clk), .rst_ni, .en_i, .y_i, .u_i, .v_i, .pal_i, .palsw_i, .mode_i,
    .valid_o, .u_o, .v_o, .hf_u_o, .hf_v_o, .comb_sel_o, .y_o
  );

  function automatic int satw(int x);
    int hi = (1 << (W - 1)) - 1;
    int lo = -(1 << (W - 1));
    return (x > hi) ? hi : ((x < lo) ? lo : x);
  endfunction

  function automatic int iabs(int x);
    return (x < 0) ? -x : x;
  endfunction

  function automatic int hsh(int n, int k);
    logic [31:0] x;
    x = 32'(n) * 32'd1103515245 + 32'(k) * 32'd12345 + 32'h9e37;
    x = x ^ (x >> 13);
    x = x * 32'd2654435761;
    return (k == 3) ? int'(x[20]) : int'($signed(x[23:16]));
  endfunction

  function automatic int gen(int p, int n, int k);
    int ln = n / L, col = n % L;
    if (k == 3 && p != 3) return (p == 4) ? (ln / 2) % 2 : ln % 2;
    case (p)
      0: return (k == 0) ? 40 : ((k == 1) ? -20 : 30);
      1: return (k == 0) ? ln * 17 - 60 : ((k == 1) ? ((ln % 2) ? 50 : -50) : (ln % 3) * 30 - 30);
      2: return (k == 0) ? (col * 13) % 97 - 48 : ((k == 1) ? (((col / 2) % 2) ? 60 : -60) : col * 9 - 50);
      3: return hsh(n, k);
      default: return (k == 0) ? ((ln % 2) ? 127 : -128) :
                      ((k == 1) ? ((ln % 2) ? -128 : 127) : ((col % 2) ? 127 : -128));
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int combv(int a, int b, int c, bit pal, int psw);
    int s = a + 2 * b + c + 2;
    if (pal) s = psw ? s + 4 * (a - c) : s - 4 * (a - c);
    return s >>> 2;
  endfunction

  task automatic expect_col(int c, logic [2:0] mode, bit pal);
    int y0, y1, y2, ya, yb, u0, u1, u2, ua, ub, v0, v1, v2, va, vb, psw;
    int ec, en, cu, cv, usel, vsel;
    bit auto_m, use_c;
    string tu;
    y0 = sy[c]; y1 = sy[c-L]; y2 = sy[c-2*L]; ya = sy[c+NS-L]; yb = sy[c-NS-L];
    u0 = su[c]; u1 = su[c-L]; u2 = su[c-2*L]; ua = su[c+NS-L]; ub = su[c-NS-L];
    v0 = sv[c]; v1 = sv[c-L]; v2 = sv[c-2*L]; va = sv[c+NS-L]; vb = sv[c-NS-L];
    psw = sp[c-L];
    ec = iabs(y0 - y1) + iabs(y2 - y1) + iabs(u0 - u2) + iabs(v0 - v2);
    en = iabs(ya - y1) + iabs(yb - y1) + iabs(ua - ub) + iabs(va - vb);
    auto_m = mode[2] | mode[1];
    use_c = auto_m ? (ec <= en) : mode[0];
    cu = combv(u0, u1, u2, pal, psw);
    cv = combv(v0, v1, v2, pal, psw);
    usel = use_c ? satw(cu) : ((ua + 2 * u1 + ub + 2) >>> 2);
    vsel = use_c ? satw(cv) : ((va + 2 * v1 + vb + 2) >>> 2);
    if (!use_c) tu = "R5";
    else if (satw(cu) != cu || satw(cv) != cv) tu = "R9";
    else tu = pal ? "R4" : "R3";
    chk(auto_m ? "R6" : "R7", "comb_sel_o", int'(comb_sel_o), int'(use_c));
    chk(tu, "u_o", int'($signed(u_o)), usel);
    chk(tu, "v_o", int'($signed(v_o)), vsel);
    chk("R8", "hf_u_o", int'($signed(hf_u_o)), satw(u1 - usel));
    chk("R8", "hf_v_o", int'($signed(hf_v_o)), satw(v1 - vsel));
    chk("R2", "y_o", int'($signed(y_o)), y1);
    chk("R10", "valid_o", int'(valid_o), 1);
  endtask

  task automatic run(int p, logic [2:0] mode, bit pal);
    logic [W-1:0] hold [6];
    rst_ni = 1'b0; en_i = 1'b0; mode_i = mode; pal_i = pal;
    @(negedge clk);
    chk("R1", "reset outputs",
        int'({valid_o, comb_sel_o, u_o, v_o, hf_u_o, hf_v_o, y_o} != '0), 0);
    rst_ni = 1'b1;
    for (int n = 0; n < N; n++) begin
      sy[n] = gen(p, n, 0); su[n] = gen(p, n, 1); sv[n] = gen(p, n, 2); sp[n] = gen(p, n, 3);
    end
    for (int n = 0; n < N; n++) begin
      y_i = W'(sy[n]); u_i = W'(su[n]); v_i = W'(sv[n]); palsw_i = sp[n][0]; en_i = 1'b1;
      @(posedge clk); @(negedge clk);
      if (n >= 2 * L + NS + LAT) expect_col(n - LAT, mode, pal);
      en_i = 1'b0;
      if (n % 5 == 3) begin
        hold[0] = u_o; hold[1] = v_o; hold[2] = hf_u_o; hold[3] = hf_v_o; hold[4] = y_o;
        hold[5] = {{(W-1){1'b0}}, comb_sel_o};
        y_i = ~y_i; u_i = ~u_i; v_i = 8'h5a; palsw_i = ~palsw_i;
        @(posedge clk); @(negedge clk);
        chk("R10", "valid_o idle", int'(valid_o), 0);
        chk("R10", "hold on idle",
            int'({u_o, v_o, hf_u_o, hf_v_o, y_o, comb_sel_o} ==
                 {hold[0], hold[1], hold[2], hold[3], hold[4], hold[5][0]}), 1);
      end
    end
  endtask

  initial begin
    logic [2:0] modes [5];
    modes[0] = 3'b100; modes[1] = 3'b000; modes[2] = 3'b001; modes[3] = 3'b010; modes[4] = 3'b111;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 5; p++)
      for (int m = 0; m < 5; m++)
        for (int pl = 0; pl < 2; pl++)
          run(p, modes[m], pl[0]);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R10 actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule